// File: doc/BRIEF.md
# Hexadecimal Floating-Point Add/Normalize Unit

This unit adds or subtracts two short-format hexadecimal floating-point words. Each word holds a sign in its most significant bit, then a 7-bit characteristic in excess-64 form, then a 24-bit fraction of six hex digits. The value of a word is the fraction times 16 raised to the power (characteristic - 64). The radix point sits just left of the fraction's top hex digit, and the sign is kept as sign and magnitude.

A one-cycle `start` pulse presents the operands together with an add/subtract select. One clock later `done` pulses, and the result word and three exception flags are valid: exponent overflow, exponent underflow and significance. Before the add, the operand with the smaller characteristic is aligned to the other by whole hex digits, and one guard digit is kept. The signed magnitudes are then combined. The sum is renormalized by hex digits and then truncated. The unit only reports exceptions and never traps.

Top module: `hex_fp_adder`

## Requirements
- R1: While reset is asserted and after it is released, `done`, all three flags and `result` are zero until the first `start`.
- R2: `done` is high exactly in the cycle after a cycle with `start` high. `result` and the flags are valid in that cycle, and `done` never rises without a preceding `start`.
- R3: Word layout: bit 31 is the sign (1 = negative), bits 30:24 are the characteristic (excess 64), and bits 23:0 are the fraction, with bits 23:20 as its high-order hex digit.
- R4: The fraction with the smaller characteristic is shifted right by the characteristic difference in whole hex digits before the add, and one extra guard digit is kept. If the difference is greater than 6, that operand counts as zero.
- R5: When operands of like effective sign produce a magnitude carry out of the fraction, the sum moves right one hex digit and the characteristic goes up by one.
- R6: With `sub` = 1 the sign of `op_b` is inverted. For operands of unlike effective sign the smaller magnitude is subtracted from the larger, and the result takes the larger one's sign.
- R7: A nonzero result is normalized. It shifts left one hex digit at a time until its high-order digit is nonzero, and the characteristic drops by one for each digit. This also applies to unnormalized inputs.
- R8: A zero result fraction gives the word 0x00000000 with only the significance flag set.
- R9: If the result characteristic would exceed 127, the exponent-overflow flag is set, and the word carries the low 7 bits of the characteristic.
- R10: If the result characteristic would fall below 0, the exponent-underflow flag is set, and the word carries the low 7 bits of the characteristic (two's-complement wrap).
- R11: The result is truncated, not rounded. The guard digit takes part in subtraction and normalization and is then dropped.
- R12: All three flags are low in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, one cycle |
| sub | input | 1 | 1 = subtract `op_b` from `op_a`, 0 = add |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| result | output | 32 | Result word, valid with `done` |
| done | output | 1 | Result-valid pulse |
| exp_ovf | output | 1 | Exponent overflow |
| exp_unf | output | 1 | Exponent underflow |
| signif | output | 1 | Zero result fraction (significance) |

## Verification
The bench builds the unit with its defaults: six fraction digits and a 7-bit characteristic, the 32-bit word. With those values a few directed operations reach both ends of the characteristic range. The defaults also make a characteristic difference of 7 reachable, which forces an operand to zero. Another case leaves a single guard-digit remainder after subtraction. One more needs four digits of left normalization.

// File: rtl/hex_fp_adder.sv
module hex_fp_adder #(
  parameter int FRAC_DIGITS = 6,
  parameter int EXP_W = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             sub,
  input  logic [4*FRAC_DIGITS+EXP_W:0]     op_a,
  input  logic [4*FRAC_DIGITS+EXP_W:0]     op_b,
  output logic [4*FRAC_DIGITS+EXP_W:0]     result,
  output logic                             done,
  output logic                             exp_ovf,
  output logic                             exp_unf,
  output logic                             signif
);
  localparam int FW = 4 * FRAC_DIGITS;
  localparam int WW = FW + EXP_W + 1;
  localparam int MW = FW + 4;
  localparam int ND = FRAC_DIGITS + 1;
  localparam int XW = EXP_W + 2;
  localparam int LW = $clog2(ND + 1);

  wire             sa = op_a[WW-1];
  wire             sb = op_b[WW-1] ^ sub;
  wire [EXP_W-1:0] ea = op_a[WW-2 -: EXP_W];
  wire [EXP_W-1:0] eb = op_b[WW-2 -: EXP_W];
  wire             a_big = ea >= eb;

  wire             s_big = a_big ? sa : sb;
  wire             s_sml = a_big ? sb : sa;
  wire [EXP_W-1:0] e_big = a_big ? ea : eb;
  wire [EXP_W-1:0] diff  = a_big ? ea - eb : eb - ea;
  wire [MW-1:0]    m_big = a_big ? {op_a[FW-1:0], 4'h0} : {op_b[FW-1:0], 4'h0};
  wire [MW-1:0]    m_raw = a_big ? {op_b[FW-1:0], 4'h0} : {op_a[FW-1:0], 4'h0};
  wire [MW-1:0]    m_sml = (diff > EXP_W'(FRAC_DIGITS)) ? '0 : m_raw >> {diff, 2'b00};

  logic [MW:0]            sum;
  logic                   r_sign;
  logic [MW-1:0]          m, m_n;
  logic [LW-1:0]          lz;
  logic                   found;
  logic signed [XW-1:0]   e;
  logic                   zero, ovf, unf;
  logic [WW-1:0]          word;

  always_comb begin
    if (s_big == s_sml) begin
      sum    = {1'b0, m_big} + {1'b0, m_sml};
      r_sign = s_big;
    end else if (m_big >= m_sml) begin
      sum    = {1'b0, m_big} - {1'b0, m_sml};
      r_sign = s_big;
    end else begin
      sum    = {1'b0, m_sml} - {1'b0, m_big};
      r_sign = s_sml;
    end
    m = sum[MW] ? {3'b000, sum[MW:4]} : sum[MW-1:0];
    lz = '0;
    found = 1'b0;
    for (int i = ND - 1; i >= 0; i--) begin
      if (!found) begin
        if (m[4*i +: 4] != 4'h0) found = 1'b1;
        else lz = lz + 1'b1;
      end
    end
    m_n  = m << {lz, 2'b00};
    e    = XW'(e_big) + XW'(sum[MW]) - XW'(lz);
    zero = (m == '0);
    ovf  = !zero && !e[XW-1] && e[EXP_W];
    unf  = !zero && e[XW-1];
    word = zero ? '0 : {r_sign, e[EXP_W-1:0], m_n[MW-1:4]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      done    <= 1'b0;
      exp_ovf <= 1'b0;
      exp_unf <= 1'b0;
      signif  <= 1'b0;
    end else begin
      done    <= start;
      exp_ovf <= start & ovf;
      exp_unf <= start & unf;
      signif  <= start & zero;
      if (start) result <= word;
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R2
  AST_NORMALIZED_OUT: assert property (@(posedge clk) disable iff (!rst_n) (done && !signif) |-> (result[FW-1 -: 4] != 4'h0)); // R7
  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n) (done && signif) |-> (result == '0 && !exp_ovf && !exp_unf)); // R8
  AST_ONE_EXP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $countones({exp_ovf, exp_unf, signif}) <= 1); // R9
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !done |-> !(exp_ovf || exp_unf || signif)); // R12
endmodule

// File: tb/hex_fp_adder_tb_top.sv
`timescale 1ns/1ps
module hex_fp_adder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sub = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, result;
  logic done, exp_ovf, exp_unf, signif;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hex_fp_adder dut_i (.clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
    .op_a(op_a), .op_b(op_b), .result(result), .done(done),
    .exp_ovf(exp_ovf), .exp_unf(exp_unf), .signif(signif));

  task automatic check(string req, logic [35:0] act, logic [35:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic run_op(string req, logic [31:0] a, logic [31:0] b, logic s,
                        logic [31:0] exp_w, logic [2:0] exp_f);
    @(negedge clk);
    op_a = a; op_b = b; sub = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, {done, exp_ovf, exp_unf, signif, result}, {1'b1, exp_f, exp_w});
    @(negedge clk);
    check({req, " R2 R12 idle"}, {32'h0, done, exp_ovf, exp_unf, signif}, 36'h0);
  endtask

  task automatic t_reset();
    check("R1 reset", {done, exp_ovf, exp_unf, signif, result}, 36'h0);
    repeat (3) @(negedge clk);
    check("R2 no start", {32'h0, done, exp_ovf, exp_unf, signif}, 36'h0);
  endtask

  task automatic t_basic();
    run_op("R3 1+1", 32'h41100000, 32'h41100000, 1'b0, 32'h41200000, 3'b000);
    run_op("R5 carry", 32'h41800000, 32'h41800000, 1'b0, 32'h42100000, 3'b000);
  endtask

  task automatic t_align();
    run_op("R4 align1", 32'h42100000, 32'h41100000, 1'b0, 32'h42110000, 3'b000);
    run_op("R4 diff7", 32'h48100000, 32'h41FFFFFF, 1'b0, 32'h48100000, 3'b000);
    run_op("R11 trunc", 32'h41100000, 32'h40FFFFFF, 1'b0, 32'h411FFFFF, 3'b000);
  endtask

  task automatic t_signs();
    run_op("R6 R7 sub", 32'h41100000, 32'h40100000, 1'b1, 32'h40F00000, 3'b000);
    run_op("R6 neg", 32'h41100000, 32'h41200000, 1'b1, 32'hC1100000, 3'b000);
    run_op("R6 nega", 32'hC1300000, 32'h41100000, 1'b0, 32'hC1200000, 3'b000);
    run_op("R11 guard", 32'h41100000, 32'h40000001, 1'b1, 32'h40FFFFFF, 3'b000);
  endtask

  task automatic t_norm();
    run_op("R7 unnorm", 32'h44000010, 32'h00000000, 1'b0, 32'h40100000, 3'b000);
  endtask

  task automatic t_except();
    run_op("R8 signif", 32'h41100000, 32'h41100000, 1'b1, 32'h00000000, 3'b001);
    run_op("R8 negzero", 32'hC2300000, 32'h42300000, 1'b0, 32'h00000000, 3'b001);
    run_op("R9 ovf", 32'h7F800000, 32'h7F800000, 1'b0, 32'h00100000, 3'b100);
    run_op("R10 unf", 32'h00100000, 32'h00010000, 1'b1, 32'h7FF00000, 3'b010);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_align();
    t_signs();
    t_norm();
    t_except();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule